// File: doc/BRIEF.md
# Predictive Flash Instruction Prefetcher

This block sits between a processor's instruction fetch port and a slow flash read port whose latency is set by a wait-state input. Flash is read one 128-bit line at a time. Each line holds four 32-bit instruction words. The block keeps two lines on chip: the line the processor is executing from, and a one-line prefetch buffer.

After an instruction fetch is accepted, the block starts a flash read of the next 16-byte aligned line, so that linear code finds its next line ready. A fetch to any other line takes the flash port in the cycle it appears, so prediction never adds latency. A pending prefetch to the same line simply continues. Data reads take the flash port away from a prefetch and cancel it. Prefetching then stays off until the next instruction fetch is accepted.

In cacheable mode, every new line handed to the processor is also presented on a fill port for an external cache array. In non-cacheable mode the fill port stays silent. If the flash has zero wait states, prefetching in non-cacheable mode is turned off.

Top module: `flash_prefetcher`

## Requirements
- R1: After reset, the block makes no flash read and raises no fetch acknowledge, no data acknowledge and no fill strobe. Both the buffer and the current line are invalid, so the first fetch is served from flash.
- R2: Once prefetch is enabled, no flash read is made until the first instruction fetch has been accepted.
- R3: The cycle after an instruction fetch is accepted with prefetch active, `fl_rd` is high and `fl_addr` is the next 16-byte aligned line. The exception is a new request that claims the flash port in that cycle.
- R4: In every cycle that a fetch is waiting, `fl_addr` holds the requested line. Flash read latency is L cycles, where L is the value of `cfg_wait`. A fetch that misses both the current line and the buffer, with the flash idle or busy on another line, is acknowledged exactly L cycles after its first cycle. No fetch waits more than L cycles.
- R5: A fetch that hits the current line or a completed prefetch buffer is acknowledged in the cycle it is presented. Address bits [3:2] select the word, and word i occupies line bits [32i+31:32i].
- R6: A data read with no pending instruction miss claims the flash port in its first cycle and cancels any prefetch. It is acknowledged after L cycles with the word selected by address bits [3:2].
- R7: After a data acknowledge, no flash read is made until another request arrives. A later fetch that hits the current line starts a prefetch of the following line in the next cycle.
- R8: With `cfg_cacheable` at 0, `fill_we` never rises. With `cfg_cacheable` at 1, `fill_we` rises with each acknowledged fetch that brings in a new line, whether from flash or from the buffer. The strobe carries that line's aligned address and data.
- R9: When `cfg_en` is 0, or when `cfg_cacheable` is 0 and `cfg_wait` is 0, no prefetch read is made after an acknowledged fetch.
- R10: With `cfg_wait` at 3 or less and one sequential word fetched per cycle, every fetch after the first line is acknowledged in the cycle it is presented.
- R11: A fetch that misses both stored lines invalidates the prefetch buffer. A later fetch to the line that was buffered goes back to flash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Prefetch enable |
| cfg_cacheable | input | 1 | 1: hand new lines to the fill port; 0: buffer only |
| cfg_wait | input | 3 | Flash wait states (read latency in cycles) |
| if_req | input | 1 | Instruction fetch request, held until acknowledged |
| if_addr | input | 32 | Instruction byte address |
| if_ack | output | 1 | Fetch acknowledge, with `if_rdata` valid |
| if_rdata | output | 32 | Fetched instruction word |
| dr_req | input | 1 | Data read request, held until acknowledged |
| dr_addr | input | 32 | Data byte address |
| dr_ack | output | 1 | Data acknowledge, with `dr_rdata` valid |
| dr_rdata | output | 32 | Data word |
| fl_rd | output | 1 | Flash read active |
| fl_addr | output | 32 | Line-aligned flash address |
| fl_valid | input | 1 | Flash line valid for the current address |
| fl_rdata | input | 128 | Flash line data |
| fill_we | output | 1 | Cache fill strobe |
| fill_addr | output | 32 | Line-aligned fill address |
| fill_data | output | 128 | Fill line data |

## Verification
The two stored lines and the prefetch flag are visible only through timing, so most state errors show up at the ports as latency errors.

- A stale buffer tag shows up at once: a fetch is acknowledged in zero cycles when it should have waited L cycles, and it returns the wrong word.
- A lost prefetch flag shows up as a stall of up to L cycles on the first word of the next line in a linear run.
- A prefetch that survives a data read shows up the cycle after the data acknowledge, as `fl_rd` high with no request pending.
- A wrong word select shows up on the same acknowledge.

// File: rtl/pf_pkg.sv
// Shared types for the flash prefetcher.
package pf_pkg;
    // Which agent currently owns the flash read port.
    typedef enum logic [1:0] {
        OWN_NONE   = 2'd0,
        OWN_DEMAND = 2'd1,
        OWN_DATA   = 2'd2,
        OWN_PREF   = 2'd3
    } fl_owner_e;
endpackage

// File: rtl/pf_word_sel.sv
// Picks one word out of a line.
// Assumes word i occupies bits [WORD_W*i +: WORD_W].
module pf_word_sel #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    localparam int SEL_W = $clog2(WORDS)
) (
    input  logic [WORD_W*WORDS-1:0] line,
    input  logic [SEL_W-1:0]        sel,
    output logic [WORD_W-1:0]       word
);
    logic [WORD_W-1:0] words [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_split
        assign words[i] = line[WORD_W*i +: WORD_W];
    end

    // Index the unpacked word array.
    assign word = words[sel];
endmodule

// File: rtl/pf_line_reg.sv
// One stored line: a valid bit, a line tag and the line data.
// It offers two tag lookups. Clear has priority over load.
module pf_line_reg #(
    parameter int TAG_W  = 28,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [LINE_W-1:0] ld_data,
    input  logic [TAG_W-1:0]  look_a,
    input  logic [TAG_W-1:0]  look_b,
    output logic              hit_a,
    output logic              hit_b,
    output logic [LINE_W-1:0] data
);
    logic             valid_q;
    logic [TAG_W-1:0] tag_q;

    // Valid bit: cleared on reset or clr, set on load.
    always_ff @(posedge clk) begin
        if (!rst_n)   valid_q <= 1'b0;
        else if (clr) valid_q <= 1'b0;
        else if (ld)  valid_q <= 1'b1;
    end

    // Tag and data capture on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
            data  <= '0;
        end else if (ld) begin
            tag_q <= ld_tag;
            data  <= ld_data;
        end
    end

    // Tag comparisons.
    assign hit_a = valid_q && (tag_q == look_a);
    assign hit_b = valid_q && (tag_q == look_b);
endmodule

// File: rtl/pf_ctrl.sv
// Flash port arbiter and prediction state.
// Priority order: instruction miss, then data read, then prefetch.
// A data grant cancels the prefetch. An accepted fetch re-arms it.
// Assumes the flash restarts its latency whenever the address changes.
module pf_ctrl
    import pf_pkg::*;
#(
    parameter int TAG_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pf_on,
    input  logic             if_miss,
    input  logic             if_ack,
    input  logic [TAG_W-1:0] if_tag,
    input  logic [TAG_W-1:0] next_tag,
    input  logic             next_held,
    input  logic             dr_req,
    input  logic [TAG_W-1:0] dr_tag,
    input  logic             fl_valid,
    output fl_owner_e        owner,
    output logic             fl_rd,
    output logic [TAG_W-1:0] fl_tag,
    output logic             pf_done
);
    logic             pf_busy_q;
    logic [TAG_W-1:0] pf_tag_q;

    // Choose the owner of the flash port in this cycle.
    always_comb begin
        owner  = OWN_NONE;
        fl_tag = pf_tag_q;
        if (if_miss) begin
            owner  = OWN_DEMAND;
            fl_tag = if_tag;
        end else if (dr_req) begin
            owner  = OWN_DATA;
            fl_tag = dr_tag;
        end else if (pf_busy_q && pf_on) begin
            owner  = OWN_PREF;
        end
    end

    assign fl_rd   = (owner != OWN_NONE);
    assign pf_done = (owner == OWN_PREF) && fl_valid;

    // Prediction state: cancel on data, arm after a fetch, drop on miss or completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_busy_q <= 1'b0;
            pf_tag_q  <= '0;
        end else if (owner == OWN_DATA) begin
            pf_busy_q <= 1'b0;
        end else if (if_ack && pf_on && !next_held) begin
            pf_busy_q <= 1'b1;
            pf_tag_q  <= next_tag;
        end else if (owner == OWN_DEMAND || pf_done) begin
            pf_busy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_prefetcher.sv
// Predictive instruction prefetcher in front of a wait-stated flash.
// It holds the current line and a one-line prefetch buffer.
// Assumes requests stay asserted until acknowledged, and that the flash
// raises fl_valid once the address has been held for cfg_wait cycles.
module flash_prefetcher
    import pf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    parameter int WS_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_en,
    input  logic                      cfg_cacheable,
    input  logic [WS_W-1:0]           cfg_wait,
    input  logic                      if_req,
    input  logic [ADDR_W-1:0]         if_addr,
    output logic                      if_ack,
    output logic [WORD_W-1:0]         if_rdata,
    input  logic                      dr_req,
    input  logic [ADDR_W-1:0]         dr_addr,
    output logic                      dr_ack,
    output logic [WORD_W-1:0]         dr_rdata,
    output logic                      fl_rd,
    output logic [ADDR_W-1:0]         fl_addr,
    input  logic                      fl_valid,
    input  logic [WORD_W*WORDS-1:0]   fl_rdata,
    output logic                      fill_we,
    output logic [ADDR_W-1:0]         fill_addr,
    output logic [WORD_W*WORDS-1:0]   fill_data
);
    localparam int LINE_W = WORD_W * WORDS;
    localparam int SEL_W  = $clog2(WORDS);
    localparam int OFF_W  = $clog2(WORDS * WORD_W / 8);
    localparam int TAG_W  = ADDR_W - OFF_W;

    logic [TAG_W-1:0]  if_tag, next_tag, dr_tag, fl_tag;
    logic              act_hit, act_next, buf_hit, buf_next;
    logic [LINE_W-1:0] act_data, buf_data, new_line, src_line;
    logic              if_miss, pf_on, pf_done;
    fl_owner_e         owner;
    logic              unused_low;

    assign if_tag     = if_addr[ADDR_W-1:OFF_W];
    assign dr_tag     = dr_addr[ADDR_W-1:OFF_W];
    assign next_tag   = if_tag + 1'b1;
    assign unused_low = ^{if_addr[OFF_W-SEL_W-1:0], dr_addr[OFF_W-SEL_W-1:0]};

    // Prediction is allowed unless it is off, or it is buffer-only with zero wait states.
    assign pf_on = cfg_en && (cfg_cacheable || (cfg_wait != '0));

    // Hit and acknowledge decode.
    assign if_miss  = if_req && !act_hit && !buf_hit;
    assign if_ack   = if_req && (act_hit || buf_hit || (owner == OWN_DEMAND && fl_valid));
    assign dr_ack   = (owner == OWN_DATA) && fl_valid;
    assign new_line = buf_hit ? buf_data : fl_rdata;
    assign src_line = act_hit ? act_data : new_line;

    pf_ctrl #(.TAG_W(TAG_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pf_on     (pf_on),
        .if_miss   (if_miss),
        .if_ack    (if_ack),
        .if_tag    (if_tag),
        .next_tag  (next_tag),
        .next_held (act_next || buf_next),
        .dr_req    (dr_req),
        .dr_tag    (dr_tag),
        .fl_valid  (fl_valid),
        .owner     (owner),
        .fl_rd     (fl_rd),
        .fl_tag    (fl_tag),
        .pf_done   (pf_done)
    );

    // Line being executed: loaded whenever a fetch brings in a new line.
    pf_line_reg #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (1'b0),
        .ld      (if_ack && !act_hit),
        .ld_tag  (if_tag),
        .ld_data (new_line),
        .look_a  (if_tag),
        .look_b  (next_tag),
        .hit_a   (act_hit),
        .hit_b   (act_next),
        .data    (act_data)
    );

    // Prefetch buffer: dropped on a miss, filled when a prediction completes.
    pf_line_reg #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (if_miss),
        .ld      (pf_done),
        .ld_tag  (fl_tag),
        .ld_data (fl_rdata),
        .look_a  (if_tag),
        .look_b  (next_tag),
        .hit_a   (buf_hit),
        .hit_b   (buf_next),
        .data    (buf_data)
    );

    pf_word_sel #(.WORD_W(WORD_W), .WORDS(WORDS)) u_if_sel (
        .line (src_line),
        .sel  (if_addr[OFF_W-1 -: SEL_W]),
        .word (if_rdata)
    );

    pf_word_sel #(.WORD_W(WORD_W), .WORDS(WORDS)) u_dr_sel (
        .line (fl_rdata),
        .sel  (dr_addr[OFF_W-1 -: SEL_W]),
        .word (dr_rdata)
    );

    assign fl_addr   = {fl_tag, {OFF_W{1'b0}}};
    assign fill_we   = cfg_cacheable && if_ack && !act_hit;
    assign fill_addr = {if_tag, {OFF_W{1'b0}}};
    assign fill_data = new_line;
endmodule

// File: rtl/pf_checks.sv
// Temporal checks for flash_prefetcher, attached with bind.
// Assumes cfg_wait is steady while a fetch is waiting.
module pf_checks #(
    parameter int ADDR_W = 32,
    parameter int WS_W   = 3,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic              cfg_cacheable,
    input logic [WS_W-1:0]   cfg_wait,
    input logic              if_req,
    input logic [ADDR_W-1:0] if_addr,
    input logic              if_ack,
    input logic              dr_req,
    input logic              dr_ack,
    input logic              fl_rd,
    input logic [ADDR_W-1:0] fl_addr,
    input logic              fill_we
);
    logic [7:0] wait_cnt;

    // Count the cycles a fetch has already waited.
    always_ff @(posedge clk) begin
        if (!rst_n)                 wait_cnt <= '0;
        else if (if_req && !if_ack) wait_cnt <= (wait_cnt == 8'hff) ? wait_cnt : wait_cnt + 8'd1;
        else                        wait_cnt <= '0;
    end

    p_miss_on_flash_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (if_req && !if_ack) |-> (fl_rd && fl_addr[ADDR_W-1:OFF_W] == if_addr[ADDR_W-1:OFF_W]));

    p_latency_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (if_req && !if_ack) |-> (wait_cnt < {{(8-WS_W){1'b0}}, cfg_wait}));

    p_no_fill_buffer_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_cacheable |-> !fill_we);

    p_fill_with_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> if_ack);

    p_quiet_after_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dr_ack) && !if_req && !dr_req) |-> !fl_rd);

    p_no_predict_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cfg_en && (cfg_cacheable || cfg_wait != '0)) && !if_req && !dr_req) |-> !fl_rd);
endmodule

bind flash_prefetcher pf_checks #(.ADDR_W(ADDR_W), .WS_W(WS_W), .OFF_W(OFF_W)) u_pf_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_en        (cfg_en),
    .cfg_cacheable (cfg_cacheable),
    .cfg_wait      (cfg_wait),
    .if_req        (if_req),
    .if_addr       (if_addr),
    .if_ack        (if_ack),
    .dr_req        (dr_req),
    .dr_ack        (dr_ack),
    .fl_rd         (fl_rd),
    .fl_addr       (fl_addr),
    .fill_we       (fill_we)
);

// File: tb/test_flash_prefetcher.sv
module test_flash_prefetcher;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_en = 1'b0, cfg_cacheable = 1'b0;
    logic [2:0]   cfg_wait = 3'd2;
    logic         if_req = 1'b0, dr_req = 1'b0;
    logic [31:0]  if_addr = '0, dr_addr = '0;
    logic         if_ack, dr_ack, fl_rd, fl_valid, fill_we;
    logic [31:0]  if_rdata, dr_rdata, fl_addr, fill_addr;
    logic [127:0] fl_rdata, fill_data;

    int n_chk = 0, n_fail = 0, bad_fill = 0;

    always #2.5 clk = ~clk;

    flash_prefetcher i_flash_prefetcher (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cacheable(cfg_cacheable),
        .cfg_wait(cfg_wait), .if_req(if_req), .if_addr(if_addr), .if_ack(if_ack),
        .if_rdata(if_rdata), .dr_req(dr_req), .dr_addr(dr_addr), .dr_ack(dr_ack),
        .dr_rdata(dr_rdata), .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_valid(fl_valid),
        .fl_rdata(fl_rdata), .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return ({2'b00, a[31:2]} * 32'h9E3779B1) ^ 32'h5A0F_C3A5;
    endfunction

    function automatic logic [127:0] line_of(input logic [31:0] a);
        logic [127:0] l;
        for (int i = 0; i < 4; i++) l[32*i +: 32] = word_of({a[31:4], i[1:0], 2'b00});
        return l;
    endfunction

    // Flash model: valid once the address has been held for cfg_wait cycles.
    logic        fm_rd_q, fm_val_q;
    logic [31:0] fm_addr_q;
    int          fm_cnt_q, fm_k;
    always_comb begin
        fm_k     = (fl_rd && fm_rd_q && !fm_val_q && fl_addr == fm_addr_q) ? fm_cnt_q + 1 : 0;
        fl_valid = fl_rd && (fm_k >= int'(cfg_wait));
        fl_rdata = line_of(fl_addr);
    end
    always_ff @(posedge clk) begin
        fm_rd_q   <= rst_n && fl_rd;
        fm_val_q  <= fl_valid;
        fm_addr_q <= fl_addr;
        fm_cnt_q  <= fm_k;
    end

    // R8: fill strobe in buffer-only mode.
    always @(posedge clk) if (rst_n && fill_we && !cfg_cacheable) bad_fill++;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Starts at a negedge; returns at the negedge after the acknowledge.
    task automatic fetch(input logic [31:0] a, output int lat, output logic [31:0] d,
                         output logic fw, output logic [31:0] fa, output logic [127:0] fd);
        if_req = 1'b1; dr_req = 1'b0; if_addr = a; lat = 0;
        forever begin
            #1;
            if (if_ack || lat > 40) break;
            @(negedge clk); lat++;
        end
        d = if_rdata; fw = fill_we; fa = fill_addr; fd = fill_data;
        @(negedge clk);
    endtask

    task automatic dread(input logic [31:0] a, output int lat, output logic [31:0] d,
                         output logic [31:0] first_fa);
        dr_req = 1'b1; if_req = 1'b0; dr_addr = a; lat = 0;
        #1; first_fa = fl_addr;
        forever begin
            if (dr_ack || lat > 40) break;
            @(negedge clk); lat++; #1;
        end
        d = dr_rdata;
        @(negedge clk);
    endtask

    task automatic peek(output logic rd, output logic [31:0] fa);
        if_req = 1'b0; dr_req = 1'b0;
        #1; rd = fl_rd; fa = fl_addr;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        logic r; logic [31:0] f;
        for (int i = 0; i < n; i++) peek(r, f);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int lat; logic [31:0] d, fa; logic fw, rd; logic [127:0] fd;
        int bad; logic [31:0] pc;
        void'($urandom(32'd20240611));
        cfg_en = 1'b1; cfg_cacheable = 1'b0; cfg_wait = 3'd2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset quiet", {if_ack, dr_ack, fl_rd, fill_we}, 4'b0);
        @(negedge clk);
        // R2: nothing before first fetch
        bad = 0;
        for (int i = 0; i < 5; i++) begin peek(rd, fa); if (rd) bad++; end
        chk("R2 no read before first fetch", bad, 0);
        // R1/R4 cold miss latency
        fetch(32'h100, lat, d, fw, fa, fd);
        chk("R4 cold miss latency", lat, 2);
        chk("R5 word data", d, word_of(32'h100));
        // R3 next line prefetch
        peek(rd, fa);
        chk("R3 prefetch next line", {rd, fa}, {1'b1, 32'h110});
        idle(3);
        fetch(32'h118, lat, d, fw, fa, fd);
        chk("R5 buffer hit latency", lat, 0);
        chk("R5 buffer hit word 2", d, word_of(32'h118));
        // R11: miss drops the buffer holding 0x110
        fetch(32'h400, lat, d, fw, fa, fd);
        chk("R4 redirect latency", lat, 2);
        fetch(32'h110, lat, d, fw, fa, fd);
        chk("R11 buffer invalidated by miss", lat, 2);
        chk("R11 data", d, word_of(32'h110));
        // R6: data preempts prefetch
        idle(4);
        fetch(32'h200, lat, d, fw, fa, fd);
        dread(32'h80C, lat, d, fa);
        chk("R6 data claims flash", fa, 32'h800);
        chk("R6 data latency", lat, 2);
        chk("R6 data word", d, word_of(32'h80C));
        // R7: quiet after data, restart on hit
        bad = 0;
        for (int i = 0; i < 4; i++) begin peek(rd, fa); if (rd) bad++; end
        chk("R7 no read after data", bad, 0);
        fetch(32'h204, lat, d, fw, fa, fd);
        chk("R7 current line hit", {lat[7:0], d}, {8'd0, word_of(32'h204)});
        peek(rd, fa);
        chk("R7 prefetch restarts on hit", {rd, fa}, {1'b1, 32'h210});
        idle(4);
        // R9: zero wait buffer-only, and disabled
        cfg_wait = 3'd0;
        fetch(32'h300, lat, d, fw, fa, fd);
        peek(rd, fa);
        chk("R9 no prefetch at zero wait", {lat[7:0], rd}, {8'd0, 1'b0});
        cfg_wait = 3'd2; cfg_en = 1'b0;
        fetch(32'h500, lat, d, fw, fa, fd);
        peek(rd, fa);
        chk("R9 no prefetch when disabled", {lat[7:0], rd}, {8'd2, 1'b0});
        chk("R8 no fill in buffer-only mode", bad_fill, 0);
        // R8: cacheable fills
        cfg_en = 1'b1; cfg_cacheable = 1'b1;
        fetch(32'h604, lat, d, fw, fa, fd);
        chk("R8 fill on flash line", {fw, fa}, {1'b1, 32'h600});
        chk("R8 fill data", fd, line_of(32'h600));
        idle(4);
        fetch(32'h610, lat, d, fw, fa, fd);
        chk("R8 fill on buffer hit", {lat[7:0], fw, fa}, {8'd0, 1'b1, 32'h610});
        fetch(32'h614, lat, d, fw, fa, fd);
        chk("R8 no fill on current line", fw, 1'b0);
        idle(4);
        // R10: linear code at wait 3
        cfg_cacheable = 1'b0; cfg_wait = 3'd3;
        idle(2);
        bad = 0;
        for (int i = 0; i < 32; i++) begin
            fetch(32'h1000 + 32'(4 * i), lat, d, fw, fa, fd);
            if (i >= 4 && lat != 0) bad++;
            if (d !== word_of(32'h1000 + 32'(4 * i))) bad++;
        end
        chk("R10 linear code without stalls", bad, 0);
        idle(4);
        // Random mix: R4, R5, R6
        pc = 32'h2000;
        for (int blk = 0; blk < 6; blk++) begin
            idle(10);
            cfg_wait = 3'($urandom_range(1, 7));
            cfg_cacheable = 1'($urandom_range(0, 1));
            cfg_en = 1'($urandom_range(0, 3) != 0);
            for (int op = 0; op < 50; op++) begin
                if ($urandom_range(0, 3) == 0) begin
                    logic [31:0] da;
                    da = {20'h0, 10'($urandom), 2'b00};
                    dread(da, lat, d, fa);
                    chk("R6 random data", {lat <= int'(cfg_wait), d}, {1'b1, word_of(da)});
                end else begin
                    pc = ($urandom_range(0, 4) == 0) ? {20'h0, 10'($urandom), 2'b00} : pc + 32'd4;
                    fetch(pc, lat, d, fw, fa, fd);
                    chk("R4 R5 random fetch", {lat <= int'(cfg_wait), d}, {1'b1, word_of(pc)});
                end
                if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 2));
            end
        end
        idle(2);
        chk("R8 no fill in buffer-only mode overall", bad_fill, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule